// File: doc/BRIEF.md
# SPI Slave Transmitter with Holding and Shift Registers

This block is the slave end of a 16-bit SPI link with separate transmit and receive paths. Software or a DMA engine writes outgoing words into a holding register. Whenever the shift register is free, the block moves the pending word into it, and the master's clock then shifts it out. In the same transaction the block assembles one incoming word from the master.

A ready flag rises each time a word moves from the holding register into the shifter. A one-cycle transmit request fires only on the 0-to-1 change of that flag. After enable, the shifter is empty, so the first written word drops straight into it and a second request follows at once. Two words are therefore loaded before the master sends its first clock, and a DMA engine sees two requests before any traffic. The receive path raises a full flag and a one-cycle request when a word is complete. Sticky flags record two errors: a pending word that was overwritten, and a transaction that ended with nothing queued.

The serial clock, chip select and data input are brought into the system clock domain through a flop chain. The block uses one fixed clock mode: it samples on the rising serial clock edge and drives on the falling edge, most significant bit first.

Top module: `spi_slave_dbuf_tx`

## Requirements
- R1: While `rst_n` is low, and while `enable` is low after reset, `tx_ready`, `tx_req`, `rx_full`, `rx_req`, `overrun`, `underrun` and `miso_out` are all 0.
- R2: `tx_req` is high for exactly one cycle, and only in the first cycle in which `tx_ready` is 1 after being 0. It never stays high while `tx_ready` holds at 1.
- R3: After `enable` rises, `tx_ready` goes to 1 in the first enabled cycle. If each request is answered by one write, exactly two requests occur before any serial clock, and two words are loaded: one in the shifter and one pending.
- R4: An accepted write sets `tx_ready` to 0. A move from the holding register into the shifter sets `tx_ready` to 1.
- R5: While `cs_n_in` is low, `miso_out` presents the shifter word MSB first. The word changes after each falling serial clock edge. Each 16-clock transaction sends the word that was loaded before that transaction began.
- R6: `mosi_in` is sampled on rising serial clock edges, MSB first. On the 16th bit, `rd_data` takes the assembled word, `rx_full` becomes 1, and `rx_req` pulses for one cycle.
- R7: A cycle with `rd_en` high clears `rx_full`, unless a new word completes in that same cycle.
- R8: A write while `tx_ready` is 0 replaces the pending word and sets the sticky `overrun` flag. The replacing word is the one transmitted.
- R9: If a transaction ends with no pending word, the shifter loads 0x0000 and the sticky `underrun` flag is set. No `tx_req` is produced, because `tx_ready` stays at 1.
- R10: Driving `enable` low clears both registers, both sticky flags, `tx_ready` and `rx_full`. A later enable repeats the two-request preload.
- R11: Serial clock edges while `cs_n_in` is high have no effect on either path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; low clears all state |
| sck_in | input | 1 | Serial clock from the master |
| cs_n_in | input | 1 | Active-low chip select from the master |
| mosi_in | input | 1 | Serial data from the master |
| miso_out | output | 1 | Serial data to the master (0 when not selected) |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 16 | Word to transmit |
| rd_en | input | 1 | Read strobe; clears the receive full flag |
| rd_data | output | 16 | Last received word |
| tx_ready | output | 1 | Holding register may take a new word |
| tx_req | output | 1 | One-cycle transmit request on ready rising |
| rx_full | output | 1 | A received word is waiting |
| rx_req | output | 1 | One-cycle receive request per word |
| overrun | output | 1 | Sticky: a pending word was overwritten |
| underrun | output | 1 | Sticky: a zero word was loaded for lack of data |

## Verification
The assertions check the following on every cycle: that requests appear only on the rising edge of the ready flag and last one cycle, that a write clears the ready flag and a move sets it, that both error flags are sticky and that overrun has a cause, that a read clears the receive flag, and that disable leaves the block quiet. Only the bench scenarios can show the rest. These are the two-request preload before any clock, the order in which queued words leave on the serial line, the zero word sent after an underrun, the replacing word sent after an overrun, and correct assembly of random received words.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
   typedef enum logic {ORDER_LSB = 1'b0, ORDER_MSB = 1'b1} bit_order_e;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic sck_in,
   input  logic cs_n_in,
   input  logic mosi_in,
   output logic rise,
   output logic fall,
   output logic active,
   output logic mosi_s,
   output logic word_end,
   output logic mid_word
);
   localparam int unsigned CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic [SYNC_STAGES-1:0] sck_p, cs_p, mosi_p;
   logic                   sck_last;
   logic [CNT_W-1:0]       cnt;
   logic                   sck_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_p    <= '0;
         cs_p     <= '1;
         mosi_p   <= '0;
         sck_last <= 1'b0;
      end else begin
         sck_p    <= {sck_p[SYNC_STAGES-2:0], sck_in};
         cs_p     <= {cs_p[SYNC_STAGES-2:0], cs_n_in};
         mosi_p   <= {mosi_p[SYNC_STAGES-2:0], mosi_in};
         sck_last <= sck_p[SYNC_STAGES-1];
      end
   end

   assign sck_s    = sck_p[SYNC_STAGES-1];
   assign mosi_s   = mosi_p[SYNC_STAGES-1];
   assign active   = enable & ~cs_p[SYNC_STAGES-1];
   assign rise     = active & sck_s & ~sck_last;
   assign fall     = active & ~sck_s & sck_last;
   assign word_end = rise && (cnt == LAST);
   assign mid_word = (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (!active)     cnt <= '0;
      else if (word_end)    cnt <= '0;
      else if (rise)        cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/spi_tx_dbuf.sv
module spi_tx_dbuf
   import spi_dbuf_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter bit_order_e  ORDER  = ORDER_MSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              fall,
   input  logic              active,
   input  logic              word_end,
   input  logic              mid_word,
   output logic              miso,
   output logic              tx_ready,
   output logic              tx_req,
   output logic              copy_evt,
   output logic              overrun,
   output logic              underrun
);
   logic [DATA_W-1:0] hold_q, shift_q, shift_nx;
   logic hold_full, shift_valid, ready_q, ready_d, en_q, ovr_q, und_q;
   logic out_bit;

   generate
      if (ORDER == ORDER_MSB) begin : g_msb
         assign shift_nx = {shift_q[DATA_W-2:0], 1'b0};
         assign out_bit  = shift_q[DATA_W-1];
      end else begin : g_lsb
         assign shift_nx = {1'b0, shift_q[DATA_W-1:1]};
         assign out_bit  = shift_q[0];
      end
   endgenerate

   assign copy_evt = hold_full & (word_end | ~shift_valid);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || !enable) begin
         hold_q <= '0; shift_q <= '0;
         hold_full <= 1'b0; shift_valid <= 1'b0;
         ready_q <= 1'b0; ready_d <= 1'b0; en_q <= 1'b0;
         ovr_q <= 1'b0; und_q <= 1'b0;
      end else begin
         en_q    <= 1'b1;
         ready_d <= ready_q;
         if (wr_en) hold_q <= wr_data;
         if (copy_evt)   hold_full <= wr_en;
         else if (wr_en) hold_full <= 1'b1;
         if (wr_en && !ready_q && en_q) ovr_q <= 1'b1;
         if (copy_evt)   ready_q <= 1'b1;
         else if (wr_en) ready_q <= 1'b0;
         else if (!en_q) ready_q <= 1'b1;
         if (copy_evt) begin
            shift_q     <= hold_q;
            shift_valid <= 1'b1;
         end else if (word_end) begin
            shift_q     <= '0;
            shift_valid <= 1'b1;
            und_q       <= 1'b1;
         end else if (fall && mid_word) begin
            shift_q <= shift_nx;
         end
      end
   end

   assign miso     = active & out_bit;
   assign tx_ready = ready_q;
   assign tx_req   = ready_q & ~ready_d;
   assign overrun  = ovr_q;
   assign underrun = und_q;
endmodule

// File: rtl/spi_rx_asm.sv
module spi_rx_asm
   import spi_dbuf_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter bit_order_e  ORDER  = ORDER_MSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              rise,
   input  logic              mosi,
   input  logic              word_end,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rx_full,
   output logic              rx_req
);
   logic [DATA_W-1:0] acc_q, acc_nx, data_q;
   logic full_q, req_q;

   generate
      if (ORDER == ORDER_MSB) begin : g_msb
         assign acc_nx = {acc_q[DATA_W-2:0], mosi};
      end else begin : g_lsb
         assign acc_nx = {mosi, acc_q[DATA_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || !enable) begin
         acc_q <= '0; data_q <= '0; full_q <= 1'b0; req_q <= 1'b0;
      end else begin
         req_q <= word_end;
         if (rise) acc_q <= acc_nx;
         if (word_end) begin
            data_q <= acc_nx;
            full_q <= 1'b1;
         end else if (rd_en) begin
            full_q <= 1'b0;
         end
      end
   end

   assign rd_data = data_q;
   assign rx_full = full_q;
   assign rx_req  = req_q;
endmodule

// File: rtl/spi_slave_dbuf_tx.sv
module spi_slave_dbuf_tx
   import spi_dbuf_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit_order_e  ORDER       = ORDER_MSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              sck_in,
   input  logic              cs_n_in,
   input  logic              mosi_in,
   output logic              miso_out,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              tx_ready,
   output logic              tx_req,
   output logic              rx_full,
   output logic              rx_req,
   output logic              overrun,
   output logic              underrun
);
   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_s
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic rise, fall, active, mosi_s, word_end, mid_word, copy_evt;

   spi_edge_sync #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .sck_in(sck_in), .cs_n_in(cs_n_in), .mosi_in(mosi_in),
      .rise(rise), .fall(fall), .active(active), .mosi_s(mosi_s),
      .word_end(word_end), .mid_word(mid_word)
   );

   spi_tx_dbuf #(.DATA_W(DATA_W), .ORDER(ORDER)) u_tx (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .wr_en(wr_en), .wr_data(wr_data),
      .fall(fall), .active(active), .word_end(word_end), .mid_word(mid_word),
      .miso(miso_out), .tx_ready(tx_ready), .tx_req(tx_req),
      .copy_evt(copy_evt), .overrun(overrun), .underrun(underrun)
   );

   spi_rx_asm #(.DATA_W(DATA_W), .ORDER(ORDER)) u_rx (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .rise(rise), .mosi(mosi_s), .word_end(word_end), .rd_en(rd_en),
      .rd_data(rd_data), .rx_full(rx_full), .rx_req(rx_req)
   );
endmodule

// File: rtl/spi_dbuf_chk.sv
module spi_dbuf_chk (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic wr_en,
   input logic rd_en,
   input logic tx_ready,
   input logic tx_req,
   input logic rx_full,
   input logic rx_req,
   input logic overrun,
   input logic underrun,
   input logic copy_evt,
   input logic word_end
);
   AST_REQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |-> (tx_ready && !$past(tx_ready))); // R2
   AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |=> !tx_req); // R2
   AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && wr_en && !copy_evt) |=> !tx_ready); // R4
   AST_COPY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && copy_evt) |=> tx_ready); // R4
   AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(enable && wr_en && !tx_ready)); // R8
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && enable) |=> overrun); // R8
   AST_UND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (underrun && enable) |=> underrun); // R9
   AST_RXREQ_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      rx_req |-> rx_full); // R6
   AST_RXREQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_req |=> !rx_req); // R6
   AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && rd_en && !word_end) |=> !rx_full); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!tx_ready && !tx_req && !rx_full && !overrun && !underrun)); // R10
endmodule

bind spi_slave_dbuf_tx spi_dbuf_chk u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en), .rd_en(rd_en),
   .tx_ready(tx_ready), .tx_req(tx_req), .rx_full(rx_full), .rx_req(rx_req),
   .overrun(overrun), .underrun(underrun), .copy_evt(copy_evt), .word_end(word_end)
);

// File: tb/tb_spi_slave_dbuf_tx.sv
`timescale 1ns/1ps
module tb_spi_slave_dbuf_tx;
   logic clk = 1'b0;
   logic rst_n, enable, sck_in, cs_n_in, mosi_in, wr_en, rd_en;
   logic [15:0] wr_data;
   logic miso_out, tx_ready, tx_req, rx_full, rx_req, overrun, underrun;
   logic [15:0] rd_data;

   always #4 clk = ~clk;

   spi_slave_dbuf_tx dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .sck_in(sck_in),
      .cs_n_in(cs_n_in), .mosi_in(mosi_in), .miso_out(miso_out),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
      .tx_ready(tx_ready), .tx_req(tx_req), .rx_full(rx_full), .rx_req(rx_req),
      .overrun(overrun), .underrun(underrun)
   );

   int errs = 0, checks = 0, n_txreq = 0, n_rxreq = 0;
   int qh = 0, qt = 0;
   logic [15:0] exp_q [0:255];
   bit auto_fill = 0, do_rd = 0, do_wr = 0;
   logic [15:0] man_data;
   logic [15:0] got;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      if (tx_req) n_txreq++;
      if (rx_req) n_rxreq++;
      wr_en = 1'b0;
      rd_en = do_rd;
      do_rd = 0;
      if (do_wr) begin
         wr_en = 1'b1; wr_data = man_data; do_wr = 0;
      end else if (auto_fill && tx_req) begin
         wr_en   = 1'b1;
         wr_data = 16'($urandom);
         exp_q[qt[7:0]] = wr_data;
         qt++;
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic xfer(input logic [15:0] mo, output logic [15:0] mi);
      cs_n_in = 1'b0;
      ticks(5);
      for (int b = 15; b >= 0; b--) begin
         mosi_in = mo[b];
         ticks(5);
         mi[b] = miso_out;
         sck_in = 1'b1;
         ticks(5);
         sck_in = 1'b0;
      end
      ticks(6);
      cs_n_in = 1'b1;
      ticks(6);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic [15:0] mo, wa, wb;
      int base;
      void'($urandom(32'h1A2B3C4D));
      rst_n = 0; enable = 0; sck_in = 0; cs_n_in = 1; mosi_in = 0;
      wr_en = 0; rd_en = 0; wr_data = 0;
      ticks(4);
      chk("R1 reset outputs", {miso_out, tx_ready, tx_req, rx_full, rx_req, overrun, underrun}, 7'd0);
      rst_n = 1;
      ticks(3);
      chk("R1 disabled outputs", {miso_out, tx_ready, tx_req, rx_full, rx_req, overrun, underrun}, 7'd0);

      // R3 preload: two requests before any clocking
      auto_fill = 1;
      enable = 1;
      ticks(12);
      chk("R3 two requests at enable", n_txreq, 2);
      chk("R3 two words written", qt, 2);
      chk("R4 ready low after second write", tx_ready, 1'b0);

      // R11 serial clocks with chip select high are ignored
      for (int i = 0; i < 16; i++) begin
         sck_in = 1; ticks(3); sck_in = 0; ticks(3);
      end
      chk("R11 no rx with cs high", {rx_full, 31'(n_rxreq)}, 32'd0);
      chk("R11 no tx request with cs high", n_txreq, 2);

      // R5/R6/R7/R2 random full-duplex traffic
      for (int k = 0; k < 30; k++) begin
         mo = 16'($urandom);
         if (k == 0) mo = 16'hFFFF;
         if (k == 1) mo = 16'h0000;
         if (k == 2) mo = 16'h8001;
         xfer(mo, got);
         chk("R5 miso word", got, exp_q[qh[7:0]]);
         qh++;
         chk("R6 rx word", rd_data, mo);
         chk("R6 rx full", rx_full, 1'b1);
         chk("R6 rx request count", n_rxreq, k + 1);
         chk("R2 one tx request per word", n_txreq, k + 3);
         if ($urandom_range(1, 0) == 1) begin
            do_rd = 1; tick(); tick();
            chk("R7 read clears full", rx_full, 1'b0);
         end
      end

      // R9 underrun
      auto_fill = 0;
      base = n_txreq;
      xfer(16'h1234, got);
      chk("R5 last queued word", got, exp_q[qh[7:0]]); qh++;
      chk("R4 copy request", n_txreq, base + 1);
      xfer(16'h5678, got);
      chk("R5 pending word", got, exp_q[qh[7:0]]); qh++;
      chk("R9 no request on underrun", n_txreq, base + 1);
      chk("R9 underrun set", underrun, 1'b1);
      xfer(16'h9ABC, got);
      chk("R9 zero word sent", got, 16'h0000);
      chk("R9 overrun still clear", overrun, 1'b0);

      // R8 overrun
      chk("R4 ready high after copy", tx_ready, 1'b1);
      wa = 16'hA5A5; wb = 16'h3C3C;
      man_data = wa; do_wr = 1; tick();
      man_data = wb; do_wr = 1; tick();
      tick(); tick();
      chk("R8 overrun set", overrun, 1'b1);
      chk("R4 ready low after write", tx_ready, 1'b0);
      base = n_txreq;
      xfer(16'h0F0F, got);
      chk("R9 zero still in shifter", got, 16'h0000);
      chk("R4 copy raises request", n_txreq, base + 1);
      xfer(16'hF0F0, got);
      chk("R8 replacing word sent", got, wb);

      // R10 disable clears, re-enable repeats preload
      enable = 0;
      ticks(3);
      chk("R10 cleared by disable", {tx_ready, rx_full, overrun, underrun}, 4'd0);
      qh = 0; qt = 0; n_txreq = 0;
      auto_fill = 1;
      enable = 1;
      ticks(12);
      chk("R10 preload repeats", n_txreq, 2);
      xfer(16'h4242, got);
      chk("R10 first word after re-enable", got, exp_q[0]);
      chk("R6 rx after re-enable", rd_data, 16'h4242);

      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule